// File: doc/BRIEF.md
# Legacy Memory Attribute Decoder

This block sits in a host bridge and classifies every memory access that falls below 1 MB. Each access is routed to one of two places: main DRAM, or out to the expansion bus. For segments marked read-only, a write still goes to the DRAM port but is tagged so that the write is dropped. The region between 640 KB and 1 MB is split into segments. Each segment has a 2-bit attribute field, and the fields are packed two to a byte in a small bank of configuration registers. The 128 KB video window is routed by a separate control byte for system-management RAM. That routing depends on whether the processor is in system-management mode.

An access request enters on a valid/ready channel and carries a 20-bit address, a write flag and the system-management-mode level. The decision leaves on a second valid/ready channel one cycle after the request is accepted. A request is accepted when `req_valid` and `req_ready` are both high on a rising edge. `req_ready` is high when the output slot is empty or when the slot is being drained in the same cycle. A result that is not taken stays unchanged until `resp_ready` is high. Configuration registers are written through a plain byte-wide write strobe and read through a combinational read port. A read-only byte reports the memory size in 8 MB units.

Top module: `lmad_top`

## Requirements
- R1: After reset `resp_valid` is 0 and `req_ready` is 1. The seven attribute bytes at offsets 0x59 to 0x5F read 0x00, and the control byte at 0x72 reads 0x02.
- R2: Any address below 0xA0000 returns target DRAM (`resp_tgt` = 2'b01) with `resp_wsup` = 0.
- R3: Addresses 0xF0000 to 0xFFFFF use bits [5:4] of byte 0x59 as their attribute.
- R4: Addresses 0xC0000 to 0xEFFFF form twelve 16 KB segments, numbered k = (addr − 0xC0000) / 0x4000. Segment k uses byte 0x5A + k/2, bits [1:0] when k is even and bits [5:4] when k is odd.
- R5: The attribute code decides the route. Code 3 gives DRAM with no suppress. Code 1 gives DRAM, with `resp_wsup` = 1 for writes and 0 for reads. Codes 0 and 2 give the bus (`resp_tgt` = 2'b10) with no suppress.
- R6: Addresses 0xA0000 to 0xBFFFF go to DRAM when bit 6 of byte 0x72 is set, or when bit 3 of byte 0x72 is set and the request's system-management-mode flag is 1. Otherwise they go to the bus. `resp_wsup` is 0 for this window.
- R7: The attribute bytes and byte 0x72 read back all 8 bits as written. Writes to any other offset have no effect, and those offsets read 0x00. The exception is 0x57 (see R8).
- R8: Byte 0x57 reads min(`mem_mb` / 8, 255) and ignores writes.
- R9: A decision uses the configuration and mode level present in the cycle the request is accepted. A configuration write in that same cycle applies only to requests accepted later. A change of the mode input after acceptance does not alter a result already produced.
- R10: `req_ready` = !`resp_valid` || `resp_ready`. While `resp_valid` is 1 and `resp_ready` is 0, `resp_tgt` and `resp_wsup` hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Access request present |
| req_ready | output | 1 | Request accepted this cycle if valid |
| req_addr | input | 20 | Access address |
| req_wr | input | 1 | 1 for write, 0 for read |
| smm_act | input | 1 | System-management mode active |
| resp_valid | output | 1 | Decision available |
| resp_ready | input | 1 | Consumer takes decision |
| resp_tgt | output | 2 | 2'b01 DRAM, 2'b10 bus |
| resp_wsup | output | 1 | Write must be dropped |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_waddr | input | 8 | Configuration write offset |
| cfg_wdata | input | 8 | Configuration write data |
| cfg_raddr | input | 8 | Configuration read offset |
| cfg_rdata | output | 8 | Configuration read data |
| mem_mb | input | 16 | Installed memory in MB |

## Verification
The bench targets the segment boundaries at 0xA0000, 0xC0000, each 16 KB step up to 0xF0000, and the top of the space. A decoder with the wrong index or the wrong nibble would send one neighbour's attribute to another segment. It also covers the read-only code with reads and with writes, and every combination of the two video-window bits with the mode flag, where a swapped condition would route the window to the wrong target. Further checks cover a configuration write in the same cycle as an accepted request, a mode change right after acceptance, and results stalled by back-pressure. These catch a design that applies settings early or lets a held result drift. The size byte is checked at and around the saturation point, and after a write to it.

// File: rtl/lmad_pkg.sv
package lmad_pkg;
  localparam int LEG_AW        = 20;
  localparam int CFG_AW        = 8;
  localparam int CFG_DW        = 8;
  localparam int ATTR_BYTES    = 7;
  localparam int SEG_CNT       = 12;
  localparam int SEG_IDX_W     = 4;
  localparam int FIELD_W       = 2;
  localparam logic [CFG_AW-1:0] OFS_ATTR  = 8'h59;
  localparam logic [CFG_AW-1:0] OFS_SMRAM = 8'h72;
  localparam logic [CFG_AW-1:0] OFS_SIZE  = 8'h57;
  localparam logic [CFG_DW-1:0] SMRAM_RST = 8'h02;
  localparam int SMRAM_OPEN_BIT = 6;
  localparam int SMRAM_SMM_BIT  = 3;
  localparam int TOP_FIELD_LSB  = 4;
  localparam int SIZE_SHIFT     = 3;

  typedef enum logic [1:0] {
    TGT_NONE = 2'b00,
    TGT_DRAM = 2'b01,
    TGT_BUS  = 2'b10
  } tgt_e;

  typedef struct packed {
    logic [LEG_AW-1:0] addr;
    logic              wr;
    logic              smm;
  } req_t;

  typedef struct packed {
    tgt_e tgt;
    logic wsup;
  } dec_t;
endpackage

// File: rtl/lmad_cfg_regs.sv
module lmad_cfg_regs
  import lmad_pkg::*;
#(
  parameter int MEM_MB_W = 16
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           we,
  input  logic [CFG_AW-1:0]              waddr,
  input  logic [CFG_DW-1:0]              wdata,
  input  logic [CFG_AW-1:0]              raddr,
  output logic [CFG_DW-1:0]              rdata,
  input  logic [MEM_MB_W-1:0]            mem_mb,
  output logic [ATTR_BYTES*CFG_DW-1:0]   attr_flat,
  output logic [CFG_DW-1:0]              smram
);
  localparam int UNITS_W = MEM_MB_W - SIZE_SHIFT;
  localparam logic [UNITS_W-1:0] SIZE_MAX = UNITS_W'(255);

  logic [CFG_DW-1:0] attr_q [ATTR_BYTES];
  logic [UNITS_W-1:0] units;
  logic [CFG_DW-1:0]  size_byte;

  for (genvar g = 0; g < ATTR_BYTES; g++) begin : g_attr
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        attr_q[g] <= '0;
      else if (we && waddr == OFS_ATTR + CFG_AW'(g))
        attr_q[g] <= wdata;
    end
    assign attr_flat[g*CFG_DW +: CFG_DW] = attr_q[g];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      smram <= SMRAM_RST;
    else if (we && waddr == OFS_SMRAM)
      smram <= wdata;
  end

  assign units     = mem_mb[MEM_MB_W-1:SIZE_SHIFT];
  assign size_byte = (units > SIZE_MAX) ? 8'hFF : units[CFG_DW-1:0];

  always_comb begin
    rdata = '0;
    if (raddr == OFS_SIZE)
      rdata = size_byte;
    else if (raddr == OFS_SMRAM)
      rdata = smram;
    else
      for (int i = 0; i < ATTR_BYTES; i++)
        if (raddr == OFS_ATTR + CFG_AW'(i))
          rdata = attr_q[i];
  end
endmodule

// File: rtl/lmad_attr_decode.sv
module lmad_attr_decode
  import lmad_pkg::*;
(
  input  logic [ATTR_BYTES*CFG_DW-1:0] attr_flat,
  input  logic [CFG_DW-1:0]            smram,
  input  req_t                         req,
  output dec_t                         dec
);
  localparam int SEG_SLOTS = 1 << SEG_IDX_W;

  logic [FIELD_W-1:0]   seg_attr [SEG_SLOTS];
  logic [FIELD_W-1:0]   top_attr;
  logic [FIELD_W-1:0]   sel_attr;
  logic [SEG_IDX_W-1:0] seg_idx;
  logic                 in_top, in_seg, in_vid, vid_dram;

  for (genvar k = 0; k < SEG_SLOTS; k++) begin : g_seg
    if (k < SEG_CNT) begin : g_live
      assign seg_attr[k] =
        attr_flat[(1 + k/2)*CFG_DW + (k%2)*TOP_FIELD_LSB +: FIELD_W];
    end else begin : g_pad
      assign seg_attr[k] = '0;
    end
  end

  assign top_attr = attr_flat[TOP_FIELD_LSB +: FIELD_W];
  assign in_top   = req.addr[LEG_AW-1 -: 4] == 4'hF;
  assign in_seg   = !in_top && req.addr[LEG_AW-1 -: 2] == 2'b11;
  assign in_vid   = req.addr[LEG_AW-1 -: 3] == 3'b101;
  assign seg_idx  = req.addr[LEG_AW-3 -: SEG_IDX_W];
  assign sel_attr = in_top ? top_attr : seg_attr[seg_idx];
  assign vid_dram = smram[SMRAM_OPEN_BIT] || (smram[SMRAM_SMM_BIT] && req.smm);

  always_comb begin
    dec.tgt  = TGT_DRAM;
    dec.wsup = 1'b0;
    if (in_top || in_seg) begin
      unique case (sel_attr)
        2'b11:   dec.tgt = TGT_DRAM;
        2'b01: begin
          dec.tgt  = TGT_DRAM;
          dec.wsup = req.wr;
        end
        default: dec.tgt = TGT_BUS;
      endcase
    end else if (in_vid) begin
      dec.tgt = vid_dram ? TGT_DRAM : TGT_BUS;
    end
  end
endmodule

// File: rtl/lmad_resp_stage.sv
module lmad_resp_stage
  import lmad_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic in_valid,
  output logic in_ready,
  input  dec_t in_dec,
  output logic out_valid,
  input  logic out_ready,
  output dec_t out_dec
);
  assign in_ready = !out_valid || out_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_dec   <= '{tgt: TGT_NONE, wsup: 1'b0};
    end else if (in_ready) begin
      out_valid <= in_valid;
      if (in_valid) out_dec <= in_dec;
    end
  end
endmodule

// File: rtl/lmad_top.sv
module lmad_top
  import lmad_pkg::*;
#(
  parameter int MEM_MB_W = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                req_valid,
  output logic                req_ready,
  input  logic [LEG_AW-1:0]   req_addr,
  input  logic                req_wr,
  input  logic                smm_act,
  output logic                resp_valid,
  input  logic                resp_ready,
  output logic [1:0]          resp_tgt,
  output logic                resp_wsup,
  input  logic                cfg_we,
  input  logic [CFG_AW-1:0]   cfg_waddr,
  input  logic [CFG_DW-1:0]   cfg_wdata,
  input  logic [CFG_AW-1:0]   cfg_raddr,
  output logic [CFG_DW-1:0]   cfg_rdata,
  input  logic [MEM_MB_W-1:0] mem_mb
);
  logic [ATTR_BYTES*CFG_DW-1:0] attr_flat;
  logic [CFG_DW-1:0]            smram;
  req_t                         req;
  dec_t                         dec_now, dec_out;

  assign req = '{addr: req_addr, wr: req_wr, smm: smm_act};

  lmad_cfg_regs #(.MEM_MB_W(MEM_MB_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .we(cfg_we), .waddr(cfg_waddr),
    .wdata(cfg_wdata), .raddr(cfg_raddr), .rdata(cfg_rdata),
    .mem_mb(mem_mb), .attr_flat(attr_flat), .smram(smram)
  );

  lmad_attr_decode u_dec (
    .attr_flat(attr_flat), .smram(smram), .req(req), .dec(dec_now)
  );

  lmad_resp_stage u_stage (
    .clk(clk), .rst_n(rst_n), .in_valid(req_valid), .in_ready(req_ready),
    .in_dec(dec_now), .out_valid(resp_valid), .out_ready(resp_ready),
    .out_dec(dec_out)
  );

  assign resp_tgt  = dec_out.tgt;
  assign resp_wsup = dec_out.wsup;
endmodule

// File: rtl/lmad_top_chk.sv
module lmad_top_chk
  import lmad_pkg::*;
#(
  parameter int MEM_MB_W = 16
) (
  input logic                clk,
  input logic                rst_n,
  input logic                req_valid,
  input logic                req_ready,
  input logic [LEG_AW-1:0]   req_addr,
  input logic                req_wr,
  input logic                smm_act,
  input logic                resp_valid,
  input logic                resp_ready,
  input logic [1:0]          resp_tgt,
  input logic                resp_wsup,
  input logic                cfg_we,
  input logic [CFG_AW-1:0]   cfg_waddr,
  input logic [CFG_DW-1:0]   cfg_wdata,
  input logic [CFG_AW-1:0]   cfg_raddr,
  input logic [CFG_DW-1:0]   cfg_rdata,
  input logic [MEM_MB_W-1:0] mem_mb
);
  assert_hold_stable_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (resp_valid && !resp_ready) |=> (resp_valid && $stable(resp_tgt) && $stable(resp_wsup)));

  assert_stall_blocks_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (resp_valid && !resp_ready) |-> !req_ready);

  assert_low_dram_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && req_addr < 20'hA0000) |=>
      (resp_valid && resp_tgt == 2'b01 && !resp_wsup));

  assert_read_no_suppress_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && !req_wr) |=> !resp_wsup);

  assert_suppress_dram_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (resp_valid && resp_wsup) |-> resp_tgt == 2'b01);

  assert_video_no_suppress_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && req_addr[19:17] == 3'b101) |=> !resp_wsup);
endmodule

bind lmad_top lmad_top_chk #(.MEM_MB_W(MEM_MB_W)) chk_i (.*);

// File: tb/lmad_top_tb_top.sv
module lmad_top_tb_top;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        req_valid = 0, req_wr = 0, smm_act = 0, resp_ready = 0;
  logic [19:0] req_addr = '0;
  logic        req_ready, resp_valid, resp_wsup;
  logic [1:0]  resp_tgt;
  logic        cfg_we = 0;
  logic [7:0]  cfg_waddr = '0, cfg_wdata = '0, cfg_raddr = '0, cfg_rdata;
  logic [15:0] mem_mb = 16'd128;

  int compared = 0, mismatched = 0, cyc = 0;
  bit done = 0;
  logic [7:0] m_attr [7];
  logic [7:0] m_smram;

  always #2.5 clk = ~clk;

  lmad_top dut_i (.*);

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc == 150000 && !done) begin
      mismatched++;
      $display("FAIL watchdog: run did not finish act=%0d exp=<150000", cyc);
      summary();
      $finish;
    end
  end

  task automatic chk(bit ok, string tag, string what, int act, int exp);
    compared++;
    if (!ok) begin
      mismatched++;
      $display("FAIL %s %s act=0x%0h exp=0x%0h", tag, what, act, exp);
    end
  endtask

  function automatic logic [2:0] model(logic [19:0] a, logic w, logic s);
    logic [1:0] f;
    int k;
    if (a < 20'hA0000) return {2'b01, 1'b0};
    if (a < 20'hC0000)
      return {(m_smram[6] || (m_smram[3] && s)) ? 2'b01 : 2'b10, 1'b0};
    if (a >= 20'hF0000) f = m_attr[0][5:4];
    else begin
      k = int'((a - 20'hC0000) / 20'h4000);
      f = (k % 2 == 1) ? m_attr[1 + k/2][5:4] : m_attr[1 + k/2][1:0];
    end
    case (f)
      2'b11: return {2'b01, 1'b0};
      2'b01: return {2'b01, w};
      default: return {2'b10, 1'b0};
    endcase
  endfunction

  function automatic string rtag(logic [19:0] a);
    if (a < 20'hA0000) return "R2";
    if (a < 20'hC0000) return "R6";
    if (a >= 20'hF0000) return "R3/R5";
    return "R4/R5";
  endfunction

  task automatic cfg_wr(logic [7:0] a, logic [7:0] d);
    @(negedge clk);
    cfg_we = 1; cfg_waddr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 0;
    if (a >= 8'h59 && a <= 8'h5F) m_attr[a - 8'h59] = d;
    if (a == 8'h72) m_smram = d;
  endtask

  task automatic rd_chk(logic [7:0] a, logic [7:0] exp, string tag);
    cfg_raddr = a;
    #0.5;
    chk(cfg_rdata == exp, tag, $sformatf("cfg read @%0h", a), cfg_rdata, exp);
  endtask

  task automatic access(logic [19:0] a, logic w, logic s, int stall, string tag,
                        logic [2:0] exp);
    @(negedge clk);
    req_addr = a; req_wr = w; smm_act = s; req_valid = 1; resp_ready = 0;
    @(negedge clk);
    req_valid = 0;
    smm_act = ~s;
    chk(resp_valid && {resp_tgt, resp_wsup} == exp, tag,
        $sformatf("decode a=%05h w=%0b smm=%0b", a, w, s),
        {resp_valid, resp_tgt, resp_wsup}, {1'b1, exp});
    for (int i = 0; i < stall; i++) begin
      @(negedge clk);
      chk(resp_valid && !req_ready && {resp_tgt, resp_wsup} == exp, "R10",
          "held under stall", {resp_valid, req_ready, resp_tgt, resp_wsup},
          {2'b10, exp});
    end
    resp_ready = 1;
    @(negedge clk);
    resp_ready = 0;
  endtask

  task automatic acc_m(logic [19:0] a, logic w, logic s, int stall);
    access(a, w, s, stall, rtag(a), model(a, w, s));
  endtask

  initial begin
    for (int i = 0; i < 7; i++) m_attr[i] = 8'h00;
    m_smram = 8'h02;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    chk(!resp_valid && req_ready, "R1", "handshake after reset",
        {resp_valid, req_ready}, 2'b01);
    for (int i = 0; i < 7; i++) rd_chk(8'h59 + 8'(i), 8'h00, "R1");
    rd_chk(8'h72, 8'h02, "R1");

    // R2 low region, with attributes set to everything
    for (int i = 0; i < 7; i++) cfg_wr(8'h59 + 8'(i), 8'hFF);
    access(20'h00000, 1, 0, 0, "R2", 3'b010);
    access(20'h9FFFF, 1, 1, 1, "R2", 3'b010);

    // R7 readback and ignored offsets
    cfg_wr(8'h5C, 8'hA5);
    rd_chk(8'h5C, 8'hA5, "R7");
    cfg_wr(8'h40, 8'h5A);
    rd_chk(8'h40, 8'h00, "R7");
    cfg_wr(8'h72, 8'hB7);
    rd_chk(8'h72, 8'hB7, "R7");
    cfg_wr(8'h72, 8'h02);

    // R8 size byte
    mem_mb = 16'd256;  rd_chk(8'h57, 8'd32, "R8");
    cfg_wr(8'h57, 8'hAA);
    rd_chk(8'h57, 8'd32, "R8");
    mem_mb = 16'd2039; rd_chk(8'h57, 8'd254, "R8");
    mem_mb = 16'd2040; rd_chk(8'h57, 8'd255, "R8");
    mem_mb = 16'd9000; rd_chk(8'h57, 8'd255, "R8");

    // R4 distinct code per segment, walk every boundary
    cfg_wr(8'h59, 8'h10);
    cfg_wr(8'h5A, 8'h31); cfg_wr(8'h5B, 8'h20); cfg_wr(8'h5C, 8'h13);
    cfg_wr(8'h5D, 8'h02); cfg_wr(8'h5E, 8'h33); cfg_wr(8'h5F, 8'h01);
    for (int k = 0; k < 12; k++) begin
      acc_m(20'hC0000 + 20'(k) * 20'h4000, 1, 0, 0);
      acc_m(20'hC0000 + 20'(k) * 20'h4000 + 20'h3FFF, 0, 0, 0);
    end
    // R3 top segment and R5 codes
    for (int c = 0; c < 4; c++) begin
      cfg_wr(8'h59, 8'(c << 4) | 8'h03);
      access(20'hF0000, 1, 0, 0, "R3/R5", model(20'hF0000, 1, 0));
      access(20'hFFFFF, 0, 0, 0, "R3/R5", model(20'hFFFFF, 0, 0));
    end
    cfg_wr(8'h59, 8'h10);
    access(20'hF8000, 1, 0, 2, "R5", 3'b011);
    access(20'hF8000, 0, 0, 0, "R5", 3'b010);

    // R6 video window matrix
    for (int b = 0; b < 4; b++) begin
      cfg_wr(8'h72, 8'((b[1] << 6) | (b[0] << 3)));
      for (int s = 0; s < 2; s++) begin
        acc_m(20'hA0000, 1, s[0], 0);
        acc_m(20'hBFFFF, 0, s[0], 0);
      end
    end

    // R9 config write in the acceptance cycle applies later
    cfg_wr(8'h59, 8'h30);
    @(negedge clk);
    cfg_we = 1; cfg_waddr = 8'h59; cfg_wdata = 8'h00;
    req_addr = 20'hF1234; req_wr = 0; smm_act = 0; req_valid = 1;
    @(negedge clk);
    cfg_we = 0; req_valid = 0;
    chk(resp_valid && {resp_tgt, resp_wsup} == 3'b010, "R9",
        "same-cycle write uses old attr", {resp_tgt, resp_wsup}, 3'b010);
    resp_ready = 1; @(negedge clk); resp_ready = 0;
    m_attr[0] = 8'h00;
    access(20'hF1234, 0, 0, 0, "R9", 3'b100);
    // R9 mode sampled at acceptance (task flips it afterwards)
    cfg_wr(8'h72, 8'h08);
    access(20'hA4000, 0, 1, 2, "R9", 3'b010);

    // random mix
    for (int n = 0; n < 400; n++) begin
      if ($urandom_range(0, 3) == 0) begin
        if ($urandom_range(0, 1) == 0)
          cfg_wr(8'h59 + 8'($urandom_range(0, 6)), 8'($urandom));
        else
          cfg_wr(8'h72, 8'($urandom));
      end
      acc_m(20'($urandom), 1'($urandom), 1'($urandom), $urandom_range(0, 2));
    end
    for (int i = 0; i < 7; i++) rd_chk(8'h59 + 8'(i), m_attr[i], "R7");
    rd_chk(8'h72, m_smram, "R7");

    done = 1;
    summary();
    $finish;
  end

  initial void'($urandom(32'h1D5EED));
endmodule